// File: doc/BRIEF.md
# Ethernet Receive Ring Buffer Writer

This block sits between a MAC that delivers received frames one byte at a time and a circular receive area in system memory. It writes every byte of a frame into the ring four bytes past the frame's start offset. After the last byte it fills that four-byte gap with a header word that holds the MAC's end-of-frame status and the frame length. It then moves its write pointer past the frame and rounds the pointer up to the next word boundary. A frame that runs past the end of the ring continues from offset 0.

Software drains the ring through a small register window. It reads the write pointer and the buffer-empty flag, and it reports how far it has consumed by writing a read pointer. The value software writes is the true offset minus 16. A 2-bit size field chooses a ring of one, two or four times a base size. A frame that would overwrite unread data is dropped. A byte that arrives while a header is being written is lost. Each of these two events sets its own interrupt flag. Software clears the interrupt flags by writing ones to them.

Top module: `rx_ring_writer`

## Requirements
- R1: The ring size is BASE_BYTES shifted left by the size field (register 1, bits 1:0). A size field of 3 acts as 2. All byte offsets wrap modulo the ring size.
- R2: Byte i of a frame that starts at write pointer W is written to offset (W+4+i) mod ring. The memory word address is offset/4, the byte is repeated on all four data lanes, and memStrb is one-hot at lane offset[1:0].
- R3: One cycle after the last byte, the header word is written at word W/4 with memStrb = 4'hF. Bits 31:16 hold the byte count of the frame, FCS included. Bits 15:0 hold the status word presented with the last byte.
- R4: After a stored frame, the write pointer becomes (W + ((len+7) AND NOT 3)) mod ring. Register 3 reads the write pointer.
- R5: Register 0 holds the software read pointer. It resets to 16'hFFF0, and the effective read offset is (value+16) mod ring.
- R6: Register 1 bit 8 (empty) reads 1 exactly when the effective read offset equals the write pointer.
- R7: Free space is (read offset − write pointer) mod ring, or the full ring size when that difference is 0. If (len+7) AND NOT 3 is not less than the free space, the frame is dropped: no header is written, no byte lands at or beyond the read offset, the write pointer does not move, and status bit 4 is set.
- R8: Status register 2 bit 0 is set when a frame is stored.
- R9: A valid byte that arrives in the header cycle sets status bit 6. The bytes of that frame up to and including its last byte are discarded. The frame before it is still stored normally.
- R10: Writing 1 to a bit of register 2 clears that bit, and writing 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R11: After reset the write pointer is 0, register 2 is 0, the size field is 0 and empty reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Frame byte valid |
| inData | input | 8 | Frame byte |
| inLast | input | 1 | Marks the last byte of a frame |
| inStatus | input | 16 | Receive status, sampled with the last byte |
| memWe | output | 1 | Memory write enable |
| memAddr | output | WORD_AW | Memory word address inside the ring |
| memData | output | 32 | Memory write data |
| memStrb | output | 4 | Byte lane enables |
| regWrite | input | 1 | Register write strobe |
| regAddr | input | 2 | Register index: 0 read pointer, 1 size/empty, 2 status, 3 write pointer |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data, combinational from regAddr |

## Verification
The assertions assume that inLast is only raised together with inValid. They also assume that software changes the size field only right after reset, and that it moves the read pointer only to a frame boundary that has already been committed. The stimulus keeps to these rules: it resets the block before each size setting, drives inLast only on a valid byte, and either writes the read pointer to the committed write pointer minus 16 or leaves it alone. The sweeps cover every frame length that fits each ring size, and the frames wrap around the ring end at every start alignment. Separate cases cover the exact drop boundary, a drop against unread data, and a byte that overlaps the header cycle.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [1:0] {
    ST_RX      = 2'd0,
    ST_HDR     = 2'd1,
    ST_DISCARD = 2'd2
  } rxState_t;

  typedef struct packed {
    logic countByte;
    logic byteWr;
    logic markDrop;
    logic latchEnd;
    logic hdrWr;
    logic commit;
    logic clearFrame;
    logic setRingOvf;
    logic setFifoOvf;
  } rxStrobe_t;

endpackage

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  input  logic      inLast,
  input  logic      byteFits,
  input  logic      frameFits,
  input  logic      dropping,
  output rxStrobe_t str
);

  rxState_t state, stateNext;

  always_comb begin
    str       = '0;
    stateNext = state;
    unique case (state)
      ST_RX: begin
        if (inValid) begin
          str.countByte = 1'b1;
          str.byteWr    = byteFits && !dropping;
          str.markDrop  = !byteFits;
          if (inLast) begin
            str.latchEnd = 1'b1;
            stateNext    = ST_HDR;
          end
        end
      end
      ST_HDR: begin
        str.clearFrame = 1'b1;
        if (frameFits && !dropping) begin
          str.hdrWr  = 1'b1;
          str.commit = 1'b1;
        end else begin
          str.setRingOvf = 1'b1;
        end
        if (inValid) begin
          str.setFifoOvf = 1'b1;
          stateNext      = inLast ? ST_RX : ST_DISCARD;
        end else begin
          stateNext = ST_RX;
        end
      end
      ST_DISCARD: begin
        if (inValid && inLast) stateNext = ST_RX;
      end
      default: stateNext = ST_RX;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RX;
    else     state <= stateNext;
  end

  // R3: the header cycle lasts exactly one cycle
  p_hdr_once_r3: assert property (@(posedge clk) disable iff (rst)
    state == ST_HDR |=> state != ST_HDR);

  // R9: an overlapping byte that is not a last byte starts a discard
  p_fifo_discard_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HDR && inValid && !inLast) |=> state == ST_DISCARD);

endmodule

// File: rtl/rxr_datapath.sv
module rxr_datapath
  import rxr_pkg::*;
#(
  parameter int BASE_BYTES = 8192,
  parameter int OFS_W      = $clog2(BASE_BYTES * 4),
  parameter int WORD_AW    = OFS_W - 2
) (
  input  logic               clk,
  input  logic               rst,
  input  rxStrobe_t          str,
  input  logic [7:0]         inData,
  input  logic [15:0]        inStatus,
  input  logic               regWrite,
  input  logic [1:0]         regAddr,
  input  logic [15:0]        regWdata,
  output logic [15:0]        regRdata,
  output logic               memWe,
  output logic [WORD_AW-1:0] memAddr,
  output logic [31:0]        memData,
  output logic [3:0]         memStrb,
  output logic               byteFits,
  output logic               frameFits,
  output logic               dropping
);

  localparam int PTR_W = OFS_W + 1;

  logic [OFS_W-1:0] wrPtr;
  logic [15:0]      cnt;
  logic [15:0]      statLat;
  logic [15:0]      rdReg;
  logic [1:0]       sizeIdx;
  logic             intOk, intRing, intFifo;

  logic [1:0]       effIdx;
  logic [PTR_W-1:0] ringBytes;
  logic [OFS_W-1:0] mask, rdTrue, diff, byteOfs, nextWr;
  logic [PTR_W-1:0] freeBytes;
  logic [16:0]      need, used;
  logic             empty, w1c;

  assign effIdx    = (sizeIdx == 2'd3) ? 2'd2 : sizeIdx;
  assign ringBytes = PTR_W'(BASE_BYTES) << effIdx;
  assign mask      = OFS_W'(ringBytes - PTR_W'(1));
  assign rdTrue    = OFS_W'(rdReg + 16'd16) & mask;
  assign diff      = (rdTrue - wrPtr) & mask;
  assign freeBytes = (diff == '0) ? ringBytes : {1'b0, diff};
  assign empty     = (rdTrue == wrPtr);

  assign used      = {1'b0, cnt} + 17'd4;
  assign need      = ({1'b0, cnt} + 17'd7) & ~17'd3;
  assign byteFits  = used < 17'(freeBytes);
  assign frameFits = need < 17'(freeBytes);
  assign byteOfs   = (wrPtr + OFS_W'(cnt) + OFS_W'(4)) & mask;
  assign nextWr    = (wrPtr + OFS_W'(need)) & mask;

  // memory write port
  always_comb begin
    memWe = str.byteWr | str.hdrWr;
    if (str.hdrWr) begin
      memAddr = wrPtr[OFS_W-1:2];
      memData = {cnt, statLat};
      memStrb = 4'hF;
    end else begin
      memAddr = byteOfs[OFS_W-1:2];
      memData = {4{inData}};
      memStrb = 4'b0001 << byteOfs[1:0];
    end
  end

  // register read
  always_comb begin
    unique case (regAddr)
      2'd0: regRdata = rdReg;
      2'd1: regRdata = {7'd0, empty, 6'd0, sizeIdx};
      2'd2: regRdata = {9'd0, intFifo, 1'b0, intRing, 3'd0, intOk};
      default: regRdata = 16'(wrPtr);
    endcase
  end

  assign w1c = regWrite && (regAddr == 2'd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr    <= '0;
      cnt      <= '0;
      dropping <= 1'b0;
      statLat  <= '0;
      rdReg    <= 16'hFFF0;
      sizeIdx  <= 2'd0;
      intOk    <= 1'b0;
      intRing  <= 1'b0;
      intFifo  <= 1'b0;
    end else begin
      if (str.countByte) cnt <= cnt + 16'd1;
      if (str.markDrop)  dropping <= 1'b1;
      if (str.latchEnd)  statLat <= inStatus;
      if (str.clearFrame) begin
        cnt      <= '0;
        dropping <= 1'b0;
      end
      if (str.commit) wrPtr <= nextWr;
      if (regWrite) begin
        if (regAddr == 2'd0) rdReg   <= regWdata;
        if (regAddr == 2'd1) sizeIdx <= regWdata[1:0];
      end
      intOk   <= (intOk   & ~(w1c & regWdata[0])) | str.commit;
      intRing <= (intRing & ~(w1c & regWdata[4])) | str.setRingOvf;
      intFifo <= (intFifo & ~(w1c & regWdata[6])) | str.setFifoOvf;
    end
  end

  // R4: the write pointer moves only on a committed frame
  p_wrptr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !str.commit |=> $stable(wrPtr));

  // R7: a data byte never lands on the effective read offset
  p_no_overwrite_r7: assert property (@(posedge clk) disable iff (rst)
    str.byteWr |-> byteOfs != rdTrue);

  // R8: a stored frame raises the receive-ok flag
  p_ok_set_r8: assert property (@(posedge clk) disable iff (rst)
    str.commit |=> intOk);

  // R10: writing 1 clears the flag when no new event arrives
  p_w1c_r10: assert property (@(posedge clk) disable iff (rst)
    (w1c && regWdata[0] && !str.commit) |=> !intOk);

  // R2: data writes enable exactly one lane
  p_lane_r2: assert property (@(posedge clk) disable iff (rst)
    str.byteWr |-> $countones(memStrb) == 1);

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int BASE_BYTES = 8192,
  parameter int OFS_W      = $clog2(BASE_BYTES * 4),
  parameter int WORD_AW    = OFS_W - 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [7:0]         inData,
  input  logic               inLast,
  input  logic [15:0]        inStatus,
  output logic               memWe,
  output logic [WORD_AW-1:0] memAddr,
  output logic [31:0]        memData,
  output logic [3:0]         memStrb,
  input  logic               regWrite,
  input  logic [1:0]         regAddr,
  input  logic [15:0]        regWdata,
  output logic [15:0]        regRdata
);

  rxStrobe_t str;
  logic byteFits, frameFits, dropping;

  rxr_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .inLast    (inLast),
    .byteFits  (byteFits),
    .frameFits (frameFits),
    .dropping  (dropping),
    .str       (str)
  );

  rxr_datapath #(
    .BASE_BYTES (BASE_BYTES),
    .OFS_W      (OFS_W),
    .WORD_AW    (WORD_AW)
  ) i_dp (
    .clk       (clk),
    .rst       (rst),
    .str       (str),
    .inData    (inData),
    .inStatus  (inStatus),
    .regWrite  (regWrite),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memData   (memData),
    .memStrb   (memStrb),
    .byteFits  (byteFits),
    .frameFits (frameFits),
    .dropping  (dropping)
  );

endmodule

// File: tb/test_rx_ring_writer.sv
`timescale 1ns/100ps
module test_rx_ring_writer;

  localparam int BASE    = 64;
  localparam int OFS_W   = $clog2(BASE * 4);
  localparam int WORD_AW = OFS_W - 2;
  localparam int WORDS   = BASE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0, inLast = 1'b0;
  logic [7:0] inData = '0;
  logic [15:0] inStatus = '0;
  logic memWe;
  logic [WORD_AW-1:0] memAddr;
  logic [31:0] memData;
  logic [3:0] memStrb;
  logic regWrite = 1'b0;
  logic [1:0] regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;

  logic [31:0] mem [WORDS];
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rx_ring_writer #(.BASE_BYTES(BASE)) i_rx_ring_writer (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .inLast(inLast),
    .inStatus(inStatus), .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .memStrb(memStrb), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  always_ff @(posedge clk) begin
    if (memWe) begin
      for (int b = 0; b < 4; b++)
        if (memStrb[b]) mem[memAddr][8*b +: 8] <= memData[8*b +: 8];
    end
  end

  function automatic logic [7:0] byteVal(input int seed, input int i);
    return 8'((seed * 13 + i * 7 + 5) & 8'hFF);
  endfunction

  function automatic logic [7:0] memByte(input int ofs);
    return mem[ofs >> 2][8 * (ofs % 4) +: 8];
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic regWr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic regRd(input logic [1:0] a, output logic [15:0] d);
    regAddr = a;
    #0.5;
    d = regRdata;
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int w = 0; w < WORDS; w++) mem[w] = 32'h0;
  endtask

  // send len bytes; extra>0 drives that many bytes right into the header cycle
  task automatic sendFrame(input int len, input logic [15:0] st, input int seed, input int extra);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid = 1'b1; inData = byteVal(seed, i);
      inLast = (i == len - 1); inStatus = st;
    end
    for (int i = 0; i < extra; i++) begin
      @(negedge clk);
      inValid = 1'b1; inData = 8'hEE; inLast = (i == extra - 1); inStatus = 16'hDEAD;
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int ring, wr, need, bad;
    doReset();

    // R11 / R5 reset state
    regRd(2'd3, d); check("R11 wrptr", 32'(d), 0);
    regRd(2'd2, d); check("R11 status", 32'(d), 0);
    regRd(2'd1, d); check("R11 empty/size", 32'(d), 32'h100);
    regRd(2'd0, d); check("R5 rdptr reset", 32'(d), 32'hFFF0);

    // Sweep all sizes (R1) and all fitting lengths (R2,R3,R4,R6,R8)
    for (int idx = 0; idx < 4; idx++) begin
      doReset();
      regWr(2'd1, 16'(idx));
      ring = BASE << ((idx == 3) ? 2 : idx);
      wr = 0;
      for (int len = 1; len <= ring - 8; len++) begin
        sendFrame(len, 16'(len * 3 + 1), len, 0);
        check("R3 header", mem[wr >> 2], {16'(len), 16'(len * 3 + 1)});
        bad = 0;
        for (int i = 0; i < len; i++)
          if (memByte((wr + 4 + i) % ring) !== byteVal(len, i)) bad++;
        check("R2 R1 data bytes wrapped", 32'(bad), 0);
        need = (len + 7) & ~3;
        wr = (wr + need) % ring;
        regRd(2'd3, d); check("R4 R1 wrptr", 32'(d), 32'(wr));
        regRd(2'd1, d); check("R6 not empty", 32'(d[8]), 0);
        regRd(2'd2, d); check("R8 rx ok", 32'(d), 32'h1);
        regWr(2'd2, 16'h0001);
        regWr(2'd0, 16'(wr - 16));
        regRd(2'd1, d); check("R6 empty", 32'(d[8]), 1);
      end
      // R7 boundary: smallest dropping length on an empty ring
      sendFrame(ring - 7, 16'h1, 3, 0);
      regRd(2'd3, d); check("R7 drop wrptr", 32'(d), 32'(wr));
      regRd(2'd2, d); check("R7 drop flag", 32'(d), 32'h10);
      regWr(2'd2, 16'h0010);
    end

    // R7 against unread data, ring 64
    doReset();
    sendFrame(20, 16'h4001, 9, 0);
    sendFrame(40, 16'h0001, 10, 0);
    regRd(2'd3, d); check("R7 unread drop wrptr", 32'(d), 24);
    check("R7 unread header intact", mem[0], {16'd20, 16'h4001});
    regRd(2'd2, d); check("R7 R8 flags", 32'(d), 32'h11);
    sendFrame(32, 16'h0001, 11, 0);
    regRd(2'd3, d); check("R7 fits exactly below", 32'(d), 60);
    sendFrame(1, 16'h0001, 12, 0);
    regRd(2'd3, d); check("R7 tiny drop", 32'(d), 60);
    check("R7 first header still intact", mem[0], {16'd20, 16'h4001});

    // R10 write-one-to-clear
    regWr(2'd2, 16'h0000);
    regRd(2'd2, d); check("R10 write zero keeps", 32'(d), 32'h11);
    regWr(2'd2, 16'h0010);
    regRd(2'd2, d); check("R10 clear bit4 only", 32'(d), 32'h01);
    regWr(2'd2, 16'h0001);
    regRd(2'd2, d); check("R10 clear bit0", 32'(d), 32'h00);

    // R9 byte overlapping the header cycle
    doReset();
    sendFrame(10, 16'h2001, 20, 3);
    regRd(2'd3, d); check("R9 previous frame stored", 32'(d), 16);
    check("R9 previous header", mem[0], {16'd10, 16'h2001});
    regRd(2'd2, d); check("R9 fifo flag", 32'(d), 32'h41);
    sendFrame(5, 16'h0001, 21, 0);
    regRd(2'd3, d); check("R9 next frame normal", 32'(d), 28);
    check("R9 next header", mem[4], {16'd5, 16'h0001});

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule